// File: doc/BRIEF.md
# Clock and Power Control Register Block

This block holds the six 32-bit control words of a system-on-chip clock and power manager: PLL lock delay, main PLL setup, USB PLL setup, clock control (gating and idle mode), slow-clock control and clock divider. Software reaches the registers through a simple synchronous bus port. The port has a byte address, a write enable with write data, and a read strobe with combinational read data. Word offsets past the last register fold onto the divider register.

The block also watches the idle-mode bit of the clock control register. When a bus write moves that bit from 0 to 1, the block sends the processor a one-cycle halt request. The comparison is made against the value stored before the write, and the new value is stored by the same write.

Top module: `clk_pwr_regs`

## Requirements
- R1: The register index is byte-address bits [4:2]. Address bits [1:0] and every bit above bit 4 have no effect on which register is selected.
- R2: The index selects registers in this order: 0 lock delay, 1 main PLL setup, 2 USB PLL setup, 3 clock control, 4 slow-clock control, 5 clock divider.
- R3: Index 6 (byte offset 0x18) and index 7 (byte offset 0x1C) reach the clock divider register (index 5), for reads and for writes.
- R4: After reset the registers hold: lock delay 0x00FFFFFF, main PLL 0x0005C080, USB PLL 0x00028080, clock control 0x0007FFF0, slow clock 0x00000004, divider 0x00000000.
- R5: All 32 bits of every register can be read and written. A read returns the last value written to that index. A register that is not written keeps its value.
- R6: While `bus_rd` is high, `bus_rdata` shows the selected register combinationally, in the same cycle. While `bus_rd` is low, `bus_rdata` is 0.
- R7: A write to clock control that changes bit 2 (the idle bit) from 0 to 1 raises `halt_req` for exactly one clock cycle, in the cycle after the write.
- R8: No halt request is raised by any of these: writing 1 to the idle bit while it is already 1, writing 0 to it, or writing a value with bit 2 set to any other register or alias.
- R9: The idle-edge test uses the value held before the write, and the written value is stored at the same edge. A read of clock control in the write cycle therefore shows the old value.
- R10: Reset is synchronous and active high. It restores every default of R4 and holds `halt_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address; bits [4:2] select the register |
| bus_wr | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| halt_req | output | 1 | One-cycle processor halt request on idle entry |

## Verification
In a single cycle, a read of clock control and the write that sets its idle bit can both occur. The bench sets up this case by raising `bus_rd` together with `bus_wr` at the clock control offset. It checks that the read data in that cycle still shows the cleared idle bit, and that the next cycle shows the halt pulse and the new value. A second collision puts a write that clears the idle bit directly after a write that set it. There the bench checks that the pulse from the first write still appears exactly once and that the clearing write adds no pulse.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_REGS   = 6;
    localparam int IDX_W      = $clog2(NUM_REGS + 2);
    localparam int WORD_LSB   = 2;
    localparam int IDLE_BIT   = 2;

    localparam int IDX_LOCK   = 0;
    localparam int IDX_MPLL   = 1;
    localparam int IDX_UPLL   = 2;
    localparam int IDX_CLKCTL = 3;
    localparam int IDX_SLOW   = 4;
    localparam int IDX_DIV    = 5;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] reg_image_t;

    typedef struct packed {
        reg_image_t regs;
    } bank_st_t;

    typedef struct packed {
        logic halt;
    } idle_st_t;

    function automatic logic [DATA_W-1:0] reset_value(int idx);
        case (idx)
            IDX_LOCK:   return 32'h00FF_FFFF;
            IDX_MPLL:   return 32'h0005_C080;
            IDX_UPLL:   return 32'h0002_8080;
            IDX_CLKCTL: return 32'h0007_FFF0;
            IDX_SLOW:   return 32'h0000_0004;
            default:    return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/cpc_index_decode.sv
module cpc_index_decode
    import cpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] raw_idx;

    always_comb begin
        raw_idx = addr[WORD_LSB +: IDX_W];
        idx     = (raw_idx > LAST_IDX) ? LAST_IDX : raw_idx;
    end

    // R3: offsets past the last register fold onto the divider
    always_comb begin
        if (addr[WORD_LSB +: IDX_W] >= IDX_W'(NUM_REGS))
            p_alias_div_r3: assert (idx == IDX_W'(IDX_DIV));
    end
endmodule

// File: rtl/cpc_reg_bank.sv
module cpc_reg_bank
    import cpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output reg_image_t        regs_o
);
    reg_image_t reset_image;
    bank_st_t   st_d, st_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_rst_img
        assign reset_image[g] = reset_value(g);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i)))
                st_d.regs[i] = wr_data;
        end
        if (rst)
            st_d.regs = reset_image;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs_o = st_q.regs;

    // R4 / R10: defaults right after reset
    p_reset_image_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs_o == reset_image));

    // R5: a write lands in the selected register
    p_store_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs_o[$past(wr_idx)] == $past(wr_data)));

    // R5: no write leaves every register unchanged
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |=> $stable(regs_o));
endmodule

// File: rtl/cpc_idle_detect.sv
module cpc_idle_detect
    import cpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic idle_old,
    input  logic idle_new,
    output logic halt_o
);
    idle_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.halt = ctl_wr && !idle_old && idle_new;
        if (rst)
            st_d.halt = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign halt_o = st_q.halt;

    // R7: the request never lasts longer than one cycle
    p_halt_single_r7: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> !halt_o);
endmodule

// File: rtl/clk_pwr_regs.sv
module clk_pwr_regs
    import cpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              halt_req
);
    logic [IDX_W-1:0] idx;
    reg_image_t       regs;
    logic             ctl_wr;

    cpc_index_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .idx  (idx)
    );

    cpc_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .regs_o  (regs)
    );

    assign ctl_wr = bus_wr && (idx == IDX_W'(IDX_CLKCTL));

    cpc_idle_detect u_idle (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .idle_old (regs[IDX_CLKCTL][IDLE_BIT]),
        .idle_new (bus_wdata[IDLE_BIT]),
        .halt_o   (halt_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd)
            bus_rdata = regs[idx];
    end

    // R7 / R9: a pulse follows a write that took the idle bit from 0 to 1
    p_halt_cause_r7: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> ($past(bus_wr) && !$past(regs[IDX_CLKCTL][IDLE_BIT])
                      && regs[IDX_CLKCTL][IDLE_BIT]));

    // R8: writes elsewhere never request a halt
    p_no_halt_other_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (idx != IDX_W'(IDX_CLKCTL)) && !$past(rst)) |=> !halt_req);

    // R10: reset keeps the request low
    p_rst_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> !halt_req);
endmodule

// File: tb/tb_clk_pwr_regs.sv
module tb_clk_pwr_regs;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic          halt_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    clk_pwr_regs #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .halt_req(halt_req)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        chk(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset_defaults(string tag);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({tag, " halt low in reset"}, {31'b0, halt_req}, 32'h0);
        rst = 1'b0;
        rd_chk({tag, " lock"},   12'h000, 32'h00FF_FFFF);
        rd_chk({tag, " mpll"},   12'h004, 32'h0005_C080);
        rd_chk({tag, " upll"},   12'h008, 32'h0002_8080);
        rd_chk({tag, " clkctl"}, 12'h00C, 32'h0007_FFF0);
        rd_chk({tag, " slow"},   12'h010, 32'h0000_0004);
        rd_chk({tag, " div"},    12'h014, 32'h0000_0000);
    endtask

    task automatic t_readwrite();
        for (int i = 0; i < 6; i++) wr(AW'(i * 4), 32'hA5A5_0000 | 32'(i));
        for (int i = 0; i < 6; i++) rd_chk("R2 R5 order", AW'(i * 4), 32'hA5A5_0000 | 32'(i));
        wr(12'h004, 32'hFFFF_FFFF);
        rd_chk("R5 all ones", 12'h004, 32'hFFFF_FFFF);
        rd_chk("R5 neighbour kept", 12'h008, 32'hA5A5_0002);
        wr(12'h004, 32'h0000_0000);
        rd_chk("R5 all zeros", 12'h004, 32'h0);
    endtask

    task automatic t_addr_bits();
        wr(12'h3A7, 32'h1234_5678);
        rd_chk("R1 high and low bits ignored", 12'h004, 32'h1234_5678);
        rd_chk("R1 read through noisy addr", 12'hFE6, 32'h1234_5678);
    endtask

    task automatic t_alias();
        wr(12'h018, 32'h0000_0B0B);
        rd_chk("R3 write 0x18 reaches divider", 12'h014, 32'h0000_0B0B);
        wr(12'h014, 32'h0000_00C3);
        rd_chk("R3 read 0x1C shows divider", 12'h01C, 32'h0000_00C3);
        rd_chk("R3 other regs untouched", 12'h010, 32'hA5A5_0004);
    endtask

    task automatic t_rd_strobe();
        @(negedge clk);
        bus_addr = 12'h000; bus_rd = 1'b0;
        #2;
        chk("R6 rdata zero without strobe", bus_rdata, 32'h0);
    endtask

    task automatic t_idle_edge();
        wr(12'h00C, 32'h0000_0000);
        chk("R8 writing 0 no halt", {31'b0, halt_req}, 32'h0);
        wr(12'h00C, 32'h0007_FFF4);
        chk("R7 halt after 0->1", {31'b0, halt_req}, 32'h1);
        @(negedge clk);
        chk("R7 halt lasts one cycle", {31'b0, halt_req}, 32'h0);
        wr(12'h00C, 32'h0000_0004);
        chk("R8 1 while 1 no halt", {31'b0, halt_req}, 32'h0);
        wr(12'h00C, 32'h0000_0000);
        wr(12'h010, 32'h0000_0004);
        chk("R8 bit2 to slow reg no halt", {31'b0, halt_req}, 32'h0);
        wr(12'h01C, 32'h0000_0004);
        chk("R8 bit2 to alias no halt", {31'b0, halt_req}, 32'h0);
    endtask

    task automatic t_same_cycle();
        wr(12'h00C, 32'h0000_0000);
        @(negedge clk);
        bus_addr = 12'h00C; bus_wdata = 32'h0000_0104; bus_wr = 1'b1; bus_rd = 1'b1;
        #2;
        chk("R9 read in write cycle shows old", bus_rdata, 32'h0);
        @(negedge clk);
        bus_wdata = 32'h0000_0000;
        #2;
        chk("R9 halt after collided write", {31'b0, halt_req}, 32'h1);
        chk("R9 new value stored", bus_rdata, 32'h0000_0104);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        #2;
        chk("R7 clearing write adds no pulse", {31'b0, halt_req}, 32'h0);
    endtask

    initial begin
        t_reset_defaults("R4");
        t_rd_strobe();
        t_readwrite();
        t_addr_bits();
        t_alias();
        t_idle_edge();
        t_same_cycle();
        wr(12'h00C, 32'h0000_0004);
        @(negedge clk);
        rst = 1'b1;
        #2;
        chk("R10 halt held low in reset", {31'b0, halt_req}, 32'h0);
        t_reset_defaults("R10");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule